// File: doc/BRIEF.md
# Audio Output Event Interrupt Controller

This block gathers buffer-event pulses from six audio outputs and turns them into a single interrupt line. Four outputs are three-wire serial outputs, and each of these reports buffer underflow and buffer empty. Two outputs are S/PDIF outputs, and each of these reports underflow, buffer empty and completion of one block transfer. Every event arrives as a one-cycle pulse.

Each source can be thinned before it reaches the status register. A 2-bit rate code lets only every first, second or fourth pulse through. One rate code covers all serial outputs, and each S/PDIF output has its own code. A pulse that gets through sets a sticky status bit. Software clears a status bit by writing 1 to it. An enable register chooses which status bits drive the interrupt.

Software reaches three registers through a select input. The select code is 0 for the rate register, 1 for the enable register and 2 for the status register. Writes take effect at the clock edge. Read data follows the select input combinationally.

Top module: `audio_irq_unit`

## Requirements
- R1: After synchronous reset, the rate, enable and status registers all read zero and `irq` is low.
- R2: Rate code 0 and rate code 3 both let every event through. The status bit is set at the clock edge that samples the pulse, and it can be read in the cycle after that edge.
- R3: Rate code 1 sets the status bit on every second event of a source. The first event after a counter reset does not set it.
- R4: Rate code 2 sets the status bit on every fourth event of a source.
- R5: The rate field at rate-register bits 13:12 governs all serial-output events. Bits 21:20 govern S/PDIF output 0, and bits 17:16 govern S/PDIF output 1. Each source keeps its own counter.
- R6: Enable and status share one bit layout, where n is the output index. Serial underflow n is at bit 3-n. S/PDIF underflow n is at bit 7-n. S/PDIF block completion n is at bit 11-n. Serial buffer-empty n is at bit 19-n. S/PDIF buffer-empty n is at bit 23-n.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a set and a clear of the same bit fall in one cycle, the bit stays set.
- R8: `irq` is the OR of every status bit ANDed with its enable bit. Status bits are set whatever the enable bits hold.
- R9: Any write to the rate register resets the event counters of all sources to zero.
- R10: Bit positions with no function read as zero and ignore writes. For the enable and status registers this mask is 0x00CF0CCF, and for the rate register it is 0x00333000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_underflow | input | 4 | Underflow pulse, one per serial output |
| ser_empty | input | 4 | Buffer-empty pulse, one per serial output |
| spd_underflow | input | 2 | Underflow pulse, one per S/PDIF output |
| spd_empty | input | 2 | Buffer-empty pulse, one per S/PDIF output |
| spd_blkdone | input | 2 | Block-transfer-complete pulse, one per S/PDIF output |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 rate, 1 enable, 2 status, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Interrupt output |

## Verification
The assertions rely on a few assumptions about the inputs:
- Event inputs are single-cycle pulses.
- The rate register changes only through a write, and that write also clears the counters. Because of this, two back-to-back pulses that get through at rate 1 or 2 can only happen across a rate write.
- The clear check looks only at cycles with no pulse that gets through, since a pulse that gets through beats a clear.

The stimulus keeps within these assumptions:
- Every event is raised for exactly one cycle.
- Rates are changed only by register writes.
- The one set-against-clear collision is a deliberate test case. It is checked through the read port.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

    localparam int REG_W   = 32;
    localparam int NSER    = 4;
    localparam int NSPD    = 2;
    localparam int CNT_W   = 2;
    localparam int RATE_W  = 2;
    localparam int SER_RATE_LSB = 12;

    typedef enum logic [RATE_W-1:0] {
        RATE_EVERY1 = 2'd0,
        RATE_EVERY2 = 2'd1,
        RATE_EVERY4 = 2'd2,
        RATE_ALT1   = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        SEL_RATE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } regsel_e;

    function automatic int spd_rate_lsb(input int n);
        return 20 - 4 * n;
    endfunction

    function automatic logic [REG_W-1:0] src_mask();
        logic [REG_W-1:0] m = '0;
        for (int n = 0; n < NSER; n++) begin
            m[3 - n]  = 1'b1;
            m[19 - n] = 1'b1;
        end
        for (int n = 0; n < NSPD; n++) begin
            m[7 - n]  = 1'b1;
            m[11 - n] = 1'b1;
            m[23 - n] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] rate_mask();
        logic [REG_W-1:0] m = '0;
        m[SER_RATE_LSB +: RATE_W] = '1;
        for (int n = 0; n < NSPD; n++)
            m = m | (REG_W'(3) << spd_rate_lsb(n));
        return m;
    endfunction

    // Rate code that governs the event source sitting at status bit p
    function automatic rate_e pos_rate(input int p, input logic [REG_W-1:0] cfg);
        rate_e r = rate_e'(cfg[SER_RATE_LSB +: RATE_W]);
        for (int n = 0; n < NSPD; n++)
            if (p == 7 - n || p == 11 - n || p == 23 - n)
                r = rate_e'(RATE_W'(cfg >> spd_rate_lsb(n)));
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] last_count(input rate_e r);
        unique case (r)
            RATE_EVERY2: return CNT_W'(1);
            RATE_EVERY4: return CNT_W'(3);
            default:     return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/aiu_decim.sv
module aiu_decim
    import audio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  evt,
    input  rate_e rate,
    output logic  tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == last_count(rate));
    assign tick = evt && wrap;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (evt)
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end

    // R3
    no_double_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && (rate == RATE_EVERY2 || rate == RATE_EVERY4)) |=> !tick);

endmodule

// File: rtl/aiu_regs.sv
module aiu_regs
    import audio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  regsel_e          sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] ticks,
    output logic [REG_W-1:0] rate_q,
    output logic [REG_W-1:0] enable_q,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] rdata
);
    localparam logic [REG_W-1:0] SRC_M  = src_mask();
    localparam logic [REG_W-1:0] RATE_M = rate_mask();

    logic wr_rate, wr_en, wr_stat;

    assign wr_rate = we && (sel == SEL_RATE);
    assign wr_en   = we && (sel == SEL_ENABLE);
    assign wr_stat = we && (sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q   <= '0;
            enable_q <= '0;
            status_q <= '0;
        end else begin
            if (wr_rate)
                rate_q <= wdata & RATE_M;
            if (wr_en)
                enable_q <= wdata & SRC_M;
            status_q <= ((status_q & ~(wr_stat ? wdata : '0)) | ticks) & SRC_M;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RATE:   rdata = rate_q;
            SEL_ENABLE: rdata = enable_q;
            SEL_STATUS: rdata = status_q;
            default:    rdata = '0;
        endcase
    end

    // R2
    tick_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(ticks)) == $past(ticks)));

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && ticks == '0) |=> ((status_q & $past(wdata)) == '0));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/audio_irq_unit.sv
module audio_irq_unit
    import audio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSER-1:0]  ser_underflow,
    input  logic [NSER-1:0]  ser_empty,
    input  logic [NSPD-1:0]  spd_underflow,
    input  logic [NSPD-1:0]  spd_empty,
    input  logic [NSPD-1:0]  spd_blkdone,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    localparam logic [REG_W-1:0] SRC_M = src_mask();

    regsel_e          sel;
    logic [REG_W-1:0] evt_map, ticks, rate_q, enable_q, status_q;
    logic             clr_cnt;

    assign sel     = regsel_e'(reg_sel);
    assign clr_cnt = reg_we && (sel == SEL_RATE);

    always_comb begin
        evt_map = '0;
        for (int n = 0; n < NSER; n++) begin
            evt_map[3 - n]  = ser_underflow[n];
            evt_map[19 - n] = ser_empty[n];
        end
        for (int n = 0; n < NSPD; n++) begin
            evt_map[7 - n]  = spd_underflow[n];
            evt_map[11 - n] = spd_blkdone[n];
            evt_map[23 - n] = spd_empty[n];
        end
    end

    for (genvar p = 0; p < REG_W; p++) begin : g_src
        if (SRC_M[p]) begin : g_live
            aiu_decim u_decim (
                .clk  (clk),
                .rst  (rst),
                .clr  (clr_cnt),
                .evt  (evt_map[p]),
                .rate (pos_rate(p, rate_q)),
                .tick (ticks[p])
            );
        end else begin : g_dead
            assign ticks[p] = 1'b0;
        end
    end

    aiu_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .sel      (sel),
        .wdata    (reg_wdata),
        .ticks    (ticks),
        .rate_q   (rate_q),
        .enable_q (enable_q),
        .status_q (status_q),
        .rdata    (reg_rdata)
    );

    assign irq = |(status_q & enable_q);

    // R8
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(|ticks) || $past(reg_we && sel == SEL_ENABLE)));

endmodule

// File: tb/test_audio_irq_unit.sv
module test_audio_irq_unit;
    import audio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ser_underflow = '0, ser_empty = '0;
    logic [1:0]  spd_underflow = '0, spd_empty = '0, spd_blkdone = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    typedef struct {
        string       tag;
        logic [1:0]  sel;
        logic [31:0] val;
        logic        irq;
    } item_t;
    item_t sb[$];
    item_t it;

    always #5 clk = ~clk;

    audio_irq_unit i_audio_irq_unit (
        .clk(clk), .rst(rst),
        .ser_underflow(ser_underflow), .ser_empty(ser_empty),
        .spd_underflow(spd_underflow), .spd_empty(spd_empty),
        .spd_blkdone(spd_blkdone),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // monitor: compare scoreboard items away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            it = sb.pop_front();
            total++;
            if (reg_rdata !== it.val || irq !== it.irq) begin
                bad++;
                $display("FAIL %s: sel=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, it.sel, reg_rdata, irq, it.val, it.irq);
            end
        end
    end

    task automatic expect_reg(input logic [1:0] sel, input logic [31:0] val,
                              input logic exp_irq, input string tag);
        @(posedge clk); #1;
        reg_sel = sel;
        sb.push_back('{tag, sel, val, exp_irq});
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic fire(input logic [3:0] su, input logic [3:0] se,
                        input logic [1:0] pu, input logic [1:0] pe,
                        input logic [1:0] pb);
        @(posedge clk); #1;
        ser_underflow = su; ser_empty = se;
        spd_underflow = pu; spd_empty = pe; spd_blkdone = pb;
        @(posedge clk); #1;
        ser_underflow = '0; ser_empty = '0;
        spd_underflow = '0; spd_empty = '0; spd_blkdone = '0;
    endtask

    initial begin
        #2_000_000;
        if (!ended) begin
            ended = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_reg(2'd0, 32'h0, 1'b0, "R1 rate");
        expect_reg(2'd1, 32'h0, 1'b0, "R1 enable");
        expect_reg(2'd2, 32'h0, 1'b0, "R1 status");

        // R10 unused bits read zero
        wr(2'd1, 32'hFFFF_FFFF);
        expect_reg(2'd1, 32'h00CF_0CCF, 1'b0, "R10 enable mask");
        wr(2'd0, 32'hFFFF_FFFF);
        expect_reg(2'd0, 32'h0033_3000, 1'b0, "R10 rate mask");
        wr(2'd1, 32'h0);

        // R2 rate code 3 acts as every event; R8 status without enable
        fire(4'b0001, 4'b0, 2'b0, 2'b0, 2'b0);
        expect_reg(2'd2, 32'h0000_0008, 1'b0, "R2/R8 status set, irq masked");
        wr(2'd1, 32'h0000_0008);
        expect_reg(2'd2, 32'h0000_0008, 1'b1, "R8 irq on enable");
        wr(2'd2, 32'h0);
        expect_reg(2'd2, 32'h0000_0008, 1'b1, "R7 write zero no effect");
        wr(2'd2, 32'h0000_0008);
        expect_reg(2'd2, 32'h0, 1'b0, "R7 write one clears");
        wr(2'd1, 32'h0);

        // R2 code 0, R6 block-complete position
        wr(2'd0, 32'h0);
        fire(4'b0, 4'b0, 2'b0, 2'b0, 2'b10);
        expect_reg(2'd2, 32'h0000_0400, 1'b0, "R6 spdif1 block done bit10");
        wr(2'd2, 32'hFFFF_FFFF);
        expect_reg(2'd2, 32'h0, 1'b0, "R10 status clear all");

        // R3/R4/R5 serial every2, spdif0 every4, spdif1 every1
        wr(2'd0, 32'h0020_1000);
        fire(4'b0, 4'b0100, 2'b0, 2'b0, 2'b0);
        expect_reg(2'd2, 32'h0, 1'b0, "R3 first event held back");
        fire(4'b0, 4'b0100, 2'b10, 2'b0, 2'b0);
        expect_reg(2'd2, 32'h0002_0040, 1'b0, "R3/R5 second event and spdif1 every1");
        wr(2'd2, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) fire(4'b0, 4'b0, 2'b0, 2'b01, 2'b0);
        expect_reg(2'd2, 32'h0, 1'b0, "R4 three events held back");
        fire(4'b0, 4'b0, 2'b0, 2'b01, 2'b0);
        expect_reg(2'd2, 32'h0080_0000, 1'b0, "R4 fourth event bit23");
        wr(2'd2, 32'hFFFF_FFFF);

        // R9 rate write resets counters
        fire(4'b0010, 4'b0, 2'b0, 2'b0, 2'b0);
        wr(2'd0, 32'h0020_1000);
        fire(4'b0010, 4'b0, 2'b0, 2'b0, 2'b0);
        expect_reg(2'd2, 32'h0, 1'b0, "R9 counter reset by rate write");
        fire(4'b0010, 4'b0, 2'b0, 2'b0, 2'b0);
        expect_reg(2'd2, 32'h0000_0004, 1'b0, "R9 second event after reset");
        wr(2'd2, 32'hFFFF_FFFF);

        // R7 set wins over simultaneous clear
        fire(4'b0, 4'b0, 2'b10, 2'b0, 2'b0);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0000_0040;
        spd_underflow = 2'b10;
        @(posedge clk); #1;
        reg_we = 1'b0; spd_underflow = 2'b00;
        expect_reg(2'd2, 32'h0000_0040, 1'b0, "R7 set beats clear");
        wr(2'd2, 32'hFFFF_FFFF);

        // R6/R8 all sources at once, one enable bit
        wr(2'd0, 32'h0);
        fire(4'hF, 4'hF, 2'b11, 2'b11, 2'b11);
        expect_reg(2'd2, 32'h00CF_0CCF, 1'b0, "R6 full layout");
        wr(2'd1, 32'h0080_0000);
        expect_reg(2'd2, 32'h00CF_0CCF, 1'b1, "R8 irq from spdif0 empty");
        wr(2'd2, 32'h0080_0000);
        expect_reg(2'd2, 32'h004F_0CCF, 1'b0, "R8 irq drops when enabled bit cleared");

        repeat (2) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule